// File: doc/BRIEF.md
# Texel Coordinate Wrapper and Tiled Offset Generator

This block takes a pair of integer texel coordinates that have already been scaled to the texture's size. It folds each coordinate back into the texture using the wrap rule chosen for that axis, then converts the folded pair into a tiled address. The address has two parts: the index of the 8x8 tile that holds the texel, and the position of the texel inside that tile.

Inside a tile, texels are ordered by nested quadrants. One bit of s and one bit of t are taken at the 2x2 level, then at the 4x4 level, then at the 8x8 level. At every level the t bit is the more significant of the pair.

The block accepts one request at a time through a valid/ready handshake. In clamp mode a result appears two cycles after the request is accepted. When either axis uses repeat mode, the remainder is computed exactly by a serial divider that does one bit per cycle, so the result takes 34 cycles. `in_ready` is low from acceptance until the result is shown. The result is held on the outputs, and `out_valid` pulses for one cycle.

Top module: `texwrap_tile`

## Requirements
- R1: Wrap code 0 clamps the axis. A negative coordinate gives 0, a coordinate at or above the size gives size minus 1, and any other coordinate passes through unchanged.
- R2: Wrap code 2 repeats the axis. The 32-bit coordinate pattern is read as an unsigned number, and the result is that number modulo the axis size. For example, -1 with size 24 gives 15.
- R3: Wrap codes 1 and 3 are unsupported. The axis that uses one gives coordinate 0 and `out_err` is 1.
- R4: The s wrap code is `cfg_wrap[9:8]` and the t wrap code is `cfg_wrap[12:11]`. The width is `cfg_size[31:16]` and the height is `cfg_size[15:0]`. All other bits of `cfg_wrap` have no effect.
- R5: An axis size of 0 gives coordinate 0 for that axis, sets `out_err` to 1, and the request still completes.
- R6: `out_texel` is {t[2], s[2], t[1], s[1], t[0], s[0]} of the wrapped coordinates, which gives a value from 0 to 63.
- R7: `out_tile` equals (t/8)·(width/8) + (s/8), using the wrapped coordinates and integer division.
- R8: `in_ready` is low from the cycle after acceptance until the cycle in which `out_valid` is 1. `out_valid` lasts one cycle. `out_err` is 0 when both axes use a supported code with a nonzero size.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_s | input | 32 | Signed s coordinate |
| in_t | input | 32 | Signed t coordinate |
| cfg_wrap | input | 32 | Wrap control word (codes at bits 9:8 and 12:11) |
| cfg_size | input | 32 | Size word: width in 31:16, height in 15:0 |
| out_valid | output | 1 | One-cycle result pulse |
| out_s | output | 16 | Wrapped s |
| out_t | output | 16 | Wrapped t |
| out_tile | output | 32 | Tile index |
| out_texel | output | 6 | Texel index within the tile |
| out_err | output | 1 | Unsupported code or zero size on some axis |

## Verification
The bench sweeps s across negative values, in-range values, values on both edges and values past the size, for every s wrap code against both supported t codes, on two non-square textures. This separates clamping from unsigned-modulo repeat: with a size that is not a power of two, a negative input gives a different result from a signed modulo. The same sweep also exposes swapped bit pairs in the quadrant index and an incorrect tile stride.

Single directed cases cover a large non-power-of-two size with negative and very large inputs, zero sizes on each axis, and garbage in the unused control bits. During every transaction the bench watches `in_ready`, and it checks that `out_valid` is only a one-cycle pulse.

// File: rtl/texwrap_tile.sv
module texwrap_tile #(
  parameter int COORD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_s,
  input  logic [COORD_W-1:0] in_t,
  input  logic [31:0]        cfg_wrap,
  input  logic [31:0]        cfg_size,
  output logic               out_valid,
  output logic [15:0]        out_s,
  output logic [15:0]        out_t,
  output logic [31:0]        out_tile,
  output logic [5:0]         out_texel,
  output logic               out_err
);
  localparam int CNT_W = $clog2(COORD_W);
  localparam logic [1:0] M_CLAMP = 2'd0;
  localparam logic [1:0] M_REPEAT = 2'd2;

  typedef enum logic [1:0] {IDLE, DIV, FIN} state_t;
  state_t state;

  logic [COORD_W-1:0] s_q, t_q;
  logic [1:0]         ms_q, mt_q;
  logic [15:0]        w_q, h_q, rem_s, rem_t;
  logic [CNT_W-1:0]   cnt;

  function automatic logic [16:0] wrap_axis(input logic [1:0] m, input logic [COORD_W-1:0] c,
                                            input logic [15:0] sz, input logic [15:0] r);
    if (sz == 16'd0) return {1'b1, 16'd0};
    if (m == M_CLAMP) begin
      if (c[COORD_W-1]) return 17'd0;
      if (c >= COORD_W'(sz)) return {1'b0, sz - 16'd1};
      return {1'b0, c[15:0]};
    end
    if (m == M_REPEAT) return {1'b0, r};
    return {1'b1, 16'd0};
  endfunction

  wire need_div = (cfg_wrap[9:8] == M_REPEAT && cfg_size[31:16] != 16'd0) ||
                  (cfg_wrap[12:11] == M_REPEAT && cfg_size[15:0] != 16'd0);

  wire [CNT_W-1:0] bit_ix = CNT_W'(COORD_W - 1) - cnt;
  wire [16:0] ps = {rem_s, s_q[bit_ix]};
  wire [16:0] pt = {rem_t, t_q[bit_ix]};
  wire [16:0] ns = (ps >= {1'b0, w_q}) ? ps - {1'b0, w_q} : ps;
  wire [16:0] nt = (pt >= {1'b0, h_q}) ? pt - {1'b0, h_q} : pt;

  wire [16:0] ws = wrap_axis(ms_q, s_q, w_q, rem_s);
  wire [16:0] wt = wrap_axis(mt_q, t_q, h_q, rem_t);
  wire [31:0] tile_c = 32'(wt[15:3]) * 32'(w_q[15:3]) + 32'(ws[15:3]);

  assign in_ready = (state == IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      {s_q, t_q} <= '0;
      {ms_q, mt_q, w_q, h_q, rem_s, rem_t} <= '0;
      cnt <= '0;
      out_valid <= 1'b0;
      {out_s, out_t, out_tile, out_texel, out_err} <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        IDLE: if (in_valid) begin
          s_q <= in_s;
          t_q <= in_t;
          ms_q <= cfg_wrap[9:8];
          mt_q <= cfg_wrap[12:11];
          w_q <= cfg_size[31:16];
          h_q <= cfg_size[15:0];
          rem_s <= '0;
          rem_t <= '0;
          cnt <= '0;
          state <= need_div ? DIV : FIN;
        end
        DIV: begin
          rem_s <= ns[15:0];
          rem_t <= nt[15:0];
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(COORD_W - 1)) state <= FIN;
        end
        default: begin
          out_valid <= 1'b1;
          out_s <= ws[15:0];
          out_t <= wt[15:0];
          out_err <= ws[16] | wt[16];
          out_tile <= tile_c;
          out_texel <= {wt[2], ws[2], wt[1], ws[1], wt[0], ws[0]};
          state <= IDLE;
        end
      endcase
    end
  end

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid);
  p_no_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_valid && !in_ready));
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DIV && w_q != 16'd0) |-> rem_s < w_q);
  p_rem_bound_t_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DIV && h_q != 16'd0) |-> rem_t < h_q);
  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> (out_s < w_q && out_t < h_q));
  p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_s == 16'd0 || out_t == 16'd0));
endmodule

// File: tb/texwrap_tile_tb_top.sv
module texwrap_tile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_s = '0, in_t = '0, cfg_wrap = '0, cfg_size = '0;
  logic out_valid, out_err;
  logic [15:0] out_s, out_t;
  logic [31:0] out_tile;
  logic [5:0] out_texel;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  texwrap_tile dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_s(in_s), .in_t(in_t), .cfg_wrap(cfg_wrap), .cfg_size(cfg_size),
    .out_valid(out_valid), .out_s(out_s), .out_t(out_t), .out_tile(out_tile),
    .out_texel(out_texel), .out_err(out_err));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint axis_exp(input int m, input logic [31:0] c, input int sz, output bit e);
    e = 0;
    if (sz == 0) begin e = 1; return 0; end
    if (m == 0) begin
      if ($signed(c) < 0) return 0;
      if ({32'b0, c} >= 64'(sz)) return sz - 1;
      return c;
    end
    if (m == 2) return longint'({32'b0, c} % 64'(sz));
    e = 1;
    return 0;
  endfunction

  task automatic run(input int ms, input int mt, input int w, input int h,
                     input logic [31:0] s, input logic [31:0] t, input logic [31:0] junk);
    longint es, et;
    bit e1, e2;
    int waited = 0;
    bit busy_ok = 1;
    es = axis_exp(ms, s, w, e1);
    et = axis_exp(mt, t, h, e2);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_s = s; in_t = t;
    cfg_wrap = (junk & ~32'h1B00) | (32'(ms) << 8) | (32'(mt) << 11);
    cfg_size = {w[15:0], h[15:0]};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && waited < 100) begin
      if (in_ready) busy_ok = 0;
      @(negedge clk);
      waited++;
    end
    chk("R8 result arrives", longint'(out_valid), 1);
    chk("R8 ready low while busy", longint'(busy_ok), 1);
    chk((ms == 0) ? "R1 s" : (ms == 2) ? "R2 s" : "R3 s", out_s, es);
    chk((mt == 0) ? "R1 t" : (mt == 2) ? "R2 t" : "R3 t", out_t, et);
    chk((e1 | e2) ? "R3/R5 err" : "R8 err clear", longint'(out_err), longint'(e1 | e2));
    chk("R6 texel", out_texel,
        {et[2], es[2], et[1], es[1], et[0], es[0]});
    chk("R7 tile", out_tile, (et / 8) * (w / 8) + es / 8);
    @(negedge clk);
    chk("R8 pulse", longint'(out_valid), 0);
  endtask

  initial begin
    int sizes[4] = '{8, 16, 24, 8};
    int tv[7] = '{-9, -1, 0, 5, 8, 23, 100};
    repeat (3) @(negedge clk);
    chk("R9 valid", longint'(out_valid), 0);
    chk("R9 ready", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready after release", longint'(in_ready), 1);
    for (int p = 0; p < 2; p++)
      for (int ms = 0; ms < 4; ms++)
        for (int mt = 0; mt < 4; mt += 2)
          for (int si = -20; si <= 40; si += 3)
            for (int ti = 0; ti < 7; ti++)
              run(ms, mt, sizes[2*p], sizes[2*p+1], 32'(si), 32'(tv[ti]), 32'hFFFF_E4FF);
    // R2 large non power of two sizes
    run(2, 2, 1000, 24, 32'hFFFF_FFF9, 32'hFFFF_FFFF, 32'h0);
    run(2, 0, 1000, 24, 32'h7FFF_FFFF, 32'd30, 32'h0);
    run(0, 2, 1000, 1000, 32'd999, 32'd5000, 32'h0);
    // R5 zero sizes
    run(0, 2, 0, 16, 32'd3, 32'd20, 32'h0);
    run(2, 0, 16, 0, 32'd3, 32'd20, 32'h0);
    run(2, 2, 0, 0, 32'hFFFF_FFFF, 32'd7, 32'h0);
    // R4 stray control bits
    run(0, 0, 16, 8, 32'd9, 32'd6, 32'hFFFF_E4FF);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule